// File: doc/BRIEF.md
# MESI Snooping Line Coherence Controller

This block keeps one cache line coherent in a write-back cache that shares a snooped bus with other caches. It takes read and write requests from its processor and decides whether they can finish locally or need a bus transaction. It also watches transactions that other caches place on the bus and reacts to them. The line is always in one of four states: Modified, Exclusive, Shared or Invalid. A line held Exclusive can be written without using the bus. A clean line held Exclusive can be passed straight to another cache on a read miss.

On a miss, the controller raises a bus request with a command: read, read-for-ownership or upgrade. It holds that request until the bus returns a completion. The completion carries a shared indication and the line data. Snooped commands arrive on a separate input. One cycle later the controller answers on its snoop outputs: a shared flag, a data-supply flag with a dirty qualifier, and the line data. In the same cycle it applies its own state change. Tag arrays, replacement policy and multi-line storage sit outside this block; it tracks one line and its data word.

Top module: `mesi_line_ctrl`

## Requirements
- R1: The state encodings are Invalid=0, Shared=1, Exclusive=2, Modified=3. The bus command encodings are none=0, read=1, read-for-ownership=2, upgrade=3. After reset the line is Invalid, and `bus_req_valid`, `cpu_done`, `snp_shared`, `snp_flush` and `snp_dirty` are all 0.
- R2: A processor read on a valid line raises `cpu_done` in the next cycle. It returns the line data, leaves the state unchanged and raises no bus request.
- R3: A processor read on an Invalid line issues command 1 and holds `bus_req_valid` until `bus_resp_valid`. The cycle after the completion, the line is Shared if `bus_resp_shared` was 1, otherwise Exclusive. In that same cycle `cpu_rdata` carries the completion data.
- R4: A processor write on an Exclusive or Modified line finishes in one cycle with no bus request. The line ends Modified and holds the write data.
- R5: A processor write on a Shared line issues command 3 (upgrade) and ends Modified after the completion.
- R6: A processor write on an Invalid line issues command 2 (read-for-ownership) and ends Modified after the completion.
- R7: A snooped command that finds the line valid raises `snp_shared` in the following cycle.
- R8: A snooped read behaves by state. A Modified line supplies its data with `snp_flush`=1 and `snp_dirty`=1 and becomes Shared. An Exclusive line supplies its data with `snp_flush`=1 and `snp_dirty`=0 and becomes Shared. A Shared line stays Shared and supplies data only when parameter SHARED_SUPPLIES is nonzero (default 0).
- R9: A snooped read-for-ownership or upgrade makes the line Invalid. A Modified line also supplies its data with `snp_dirty`=1.
- R10: A snoop takes precedence over a processor request presented in the same cycle. The request is not acted on that cycle and is served afterwards against the updated state.
- R11: If a pending upgrade request sees a snoop that invalidates the line, the request turns into a read-for-ownership (command 2) before it is granted.
- R12: Across two controllers on one bus, a line held Modified or Exclusive in one is never valid in the other, and every read returns the most recently written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request, held until `cpu_done` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | DW | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| bus_req_valid | output | 1 | Bus transaction pending |
| bus_req_cmd | output | 2 | Requested bus command |
| bus_resp_valid | input | 1 | Own transaction completed |
| bus_resp_shared | input | 1 | Another cache held the line |
| bus_resp_data | input | DW | Line data for the completed read |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_shared | output | 1 | Line was valid at the snoop |
| snp_flush | output | 1 | This cache supplies the data |
| snp_dirty | output | 1 | Supplied data is newer than memory |
| snp_data | output | DW | Supplied line data |
| line_state | output | 2 | Current coherence state |

## Verification
The functions that can collide are a processor request and a snooped transaction for the same line. The bench provokes the collision in two ways. First, it presents a write to an Exclusive line in the exact cycle the other cache's read is snooped in. This must downgrade the line first and then cost a bus upgrade instead of a silent write. Second, it fires writes from two Shared holders together, so that the losing upgrade sees its line invalidated while waiting. Each case is judged on the final states, on the command each controller put on the bus, on write-back to memory and on a later read, against a bench model of the two caches and memory.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHD = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_UPG  = 2'd3
  } bus_cmd_e;

  typedef struct packed {
    line_st_e nxt;
    logic     shared;
    logic     supply;
    logic     dirty;
  } snp_act_t;
endpackage

// File: rtl/mesi_snoop_unit.sv
`timescale 1ns/1ps
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int SHARED_SUPPLIES = 0
) (
  input  logic     hit,
  input  line_st_e cur,
  input  bus_cmd_e cmd,
  output snp_act_t act
);
  logic shd_supply;

  generate
    if (SHARED_SUPPLIES != 0) begin : g_shd_gives
      assign shd_supply = 1'b1;
    end else begin : g_mem_gives
      assign shd_supply = 1'b0;
    end
  endgenerate

  always_comb begin
    act.nxt    = cur;
    act.shared = 1'b0;
    act.supply = 1'b0;
    act.dirty  = 1'b0;
    if (hit && cur != LS_INV) begin
      act.shared = 1'b1;
      case (cmd)
        BC_RD: begin
          case (cur)
            LS_MOD: begin
              act.nxt    = LS_SHD;
              act.supply = 1'b1;
              act.dirty  = 1'b1;
            end
            LS_EXC: begin
              act.nxt    = LS_SHD;
              act.supply = 1'b1;
            end
            default: act.supply = shd_supply;
          endcase
        end
        BC_RDX, BC_UPG: begin
          act.nxt = LS_INV;
          if (cur == LS_MOD) begin
            act.supply = 1'b1;
            act.dirty  = 1'b1;
          end
        end
        default: act.nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/mesi_req_unit.sv
`timescale 1ns/1ps
module mesi_req_unit
  import mesi_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req_valid,
  input  logic          cpu_req_write,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          snp_hit,
  input  logic          snp_kills,
  input  line_st_e      cur,
  input  logic [DW-1:0] line_data,
  input  logic          bus_resp_valid,
  input  logic          bus_resp_shared,
  input  logic [DW-1:0] bus_resp_data,
  output logic          busy,
  output bus_cmd_e      cmd,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          upd_st_en,
  output line_st_e      upd_st,
  output logic          upd_dat_en,
  output logic [DW-1:0] upd_dat
);
  logic          busy_q;
  bus_cmd_e      cmd_q;
  logic          done_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] pend_wdata_q;

  logic     accept, hit_rd, hit_wr, miss, finish;
  bus_cmd_e miss_cmd;

  always_comb begin
    accept   = cpu_req_valid && !snp_hit && !done_q && !busy_q;
    hit_rd   = accept && !cpu_req_write && (cur != LS_INV);
    hit_wr   = accept && cpu_req_write && (cur == LS_MOD || cur == LS_EXC);
    miss     = accept && !hit_rd && !hit_wr;
    finish   = busy_q && bus_resp_valid;
    if (!cpu_req_write)      miss_cmd = BC_RD;
    else if (cur == LS_SHD)  miss_cmd = BC_UPG;
    else                     miss_cmd = BC_RDX;
  end

  always_comb begin
    upd_st_en  = 1'b0;
    upd_st     = cur;
    upd_dat_en = 1'b0;
    upd_dat    = cpu_wdata;
    if (hit_wr) begin
      upd_st_en  = 1'b1;
      upd_st     = LS_MOD;
      upd_dat_en = 1'b1;
    end else if (finish) begin
      upd_st_en  = 1'b1;
      upd_dat_en = 1'b1;
      if (cmd_q == BC_RD) begin
        upd_st  = bus_resp_shared ? LS_SHD : LS_EXC;
        upd_dat = bus_resp_data;
      end else begin
        upd_st  = LS_MOD;
        upd_dat = pend_wdata_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      cmd_q        <= BC_NONE;
      done_q       <= 1'b0;
      rdata_q      <= '0;
      pend_wdata_q <= '0;
    end else begin
      done_q <= hit_rd || hit_wr || finish;
      if (hit_rd)
        rdata_q <= line_data;
      else if (finish && cmd_q == BC_RD)
        rdata_q <= bus_resp_data;
      if (miss) begin
        busy_q       <= 1'b1;
        cmd_q        <= miss_cmd;
        pend_wdata_q <= cpu_wdata;
      end else if (finish) begin
        busy_q <= 1'b0;
        cmd_q  <= BC_NONE;
      end else if (busy_q && snp_kills && cmd_q == BC_UPG) begin
        cmd_q <= BC_RDX;
      end
    end
  end

  assign busy  = busy_q;
  assign cmd   = cmd_q;
  assign done  = done_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int DW              = 32,
  parameter int SHARED_SUPPLIES = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req_valid,
  input  logic          cpu_req_write,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req_valid,
  output logic [1:0]    bus_req_cmd,
  input  logic          bus_resp_valid,
  input  logic          bus_resp_shared,
  input  logic [DW-1:0] bus_resp_data,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  output logic          snp_shared,
  output logic          snp_flush,
  output logic          snp_dirty,
  output logic [DW-1:0] snp_data,
  output logic [1:0]    line_state
);
  line_st_e      state_q;
  logic [DW-1:0] data_q;
  snp_act_t      act;

  logic          busy;
  bus_cmd_e      cmd;
  logic          upd_st_en, upd_dat_en;
  line_st_e      upd_st;
  logic [DW-1:0] upd_dat;
  logic          snp_kills;

  logic          shared_q, flush_q, dirty_q;
  logic [DW-1:0] sdata_q;

  mesi_snoop_unit #(.SHARED_SUPPLIES(SHARED_SUPPLIES)) u_snoop (
    .hit (snp_valid),
    .cur (state_q),
    .cmd (bus_cmd_e'(snp_cmd)),
    .act (act)
  );

  assign snp_kills = snp_valid && (act.nxt == LS_INV);

  mesi_req_unit #(.DW(DW)) u_req (
    .clk             (clk),
    .rst             (rst),
    .cpu_req_valid   (cpu_req_valid),
    .cpu_req_write   (cpu_req_write),
    .cpu_wdata       (cpu_wdata),
    .snp_hit         (snp_valid),
    .snp_kills       (snp_kills),
    .cur             (state_q),
    .line_data       (data_q),
    .bus_resp_valid  (bus_resp_valid),
    .bus_resp_shared (bus_resp_shared),
    .bus_resp_data   (bus_resp_data),
    .busy            (busy),
    .cmd             (cmd),
    .done            (cpu_done),
    .rdata           (cpu_rdata),
    .upd_st_en       (upd_st_en),
    .upd_st          (upd_st),
    .upd_dat_en      (upd_dat_en),
    .upd_dat         (upd_dat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= LS_INV;
      data_q   <= '0;
      shared_q <= 1'b0;
      flush_q  <= 1'b0;
      dirty_q  <= 1'b0;
      sdata_q  <= '0;
    end else begin
      if (snp_valid)
        state_q <= act.nxt;
      else if (upd_st_en)
        state_q <= upd_st;
      if (upd_dat_en && !snp_valid)
        data_q <= upd_dat;
      shared_q <= snp_valid && act.shared;
      flush_q  <= snp_valid && act.supply;
      dirty_q  <= snp_valid && act.dirty;
      sdata_q  <= (snp_valid && act.supply) ? data_q : '0;
    end
  end

  assign bus_req_valid = busy;
  assign bus_req_cmd   = cmd;
  assign snp_shared    = shared_q;
  assign snp_flush     = flush_q;
  assign snp_dirty     = dirty_q;
  assign snp_data      = sdata_q;
  assign line_state    = state_q;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
`timescale 1ns/1ps
module mesi_line_ctrl_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req_valid,
  input logic          cpu_req_write,
  input logic          cpu_done,
  input logic [DW-1:0] cpu_rdata,
  input logic          bus_req_valid,
  input logic [1:0]    bus_req_cmd,
  input logic          bus_resp_valid,
  input logic          bus_resp_shared,
  input logic [DW-1:0] bus_resp_data,
  input logic          snp_valid,
  input logic [1:0]    snp_cmd,
  input logic          snp_shared,
  input logic          snp_flush,
  input logic          snp_dirty,
  input logic [1:0]    line_state
);
  logic idle_take;
  assign idle_take = cpu_req_valid && !snp_valid && !cpu_done && !bus_req_valid;

  assert_busy_has_cmd_R1: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid |-> bus_req_cmd != 2'd0);

  assert_read_hit_local_R2: assert property (@(posedge clk) disable iff (rst)
    (idle_take && !cpu_req_write && line_state != 2'd0)
    |=> (cpu_done && !bus_req_valid && line_state == $past(line_state)));

  assert_read_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_req_cmd == 2'd1 && bus_resp_valid && !snp_valid)
    |=> (cpu_done && line_state == ($past(bus_resp_shared) ? 2'd1 : 2'd2)
         && cpu_rdata == $past(bus_resp_data)));

  assert_silent_write_R4: assert property (@(posedge clk) disable iff (rst)
    (idle_take && cpu_req_write && line_state == 2'd2)
    |=> (line_state == 2'd3 && cpu_done && !bus_req_valid));

  assert_upgrade_issue_R5: assert property (@(posedge clk) disable iff (rst)
    (idle_take && cpu_req_write && line_state == 2'd1)
    |=> (bus_req_valid && bus_req_cmd == 2'd3));

  assert_rdx_issue_R6: assert property (@(posedge clk) disable iff (rst)
    (idle_take && cpu_req_write && line_state == 2'd0)
    |=> (bus_req_valid && bus_req_cmd == 2'd2));

  assert_shared_reply_R7: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && line_state != 2'd0) |=> snp_shared);

  assert_dirty_flush_R8: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_cmd == 2'd1 && line_state == 2'd3)
    |=> (line_state == 2'd1 && snp_flush && snp_dirty));

  assert_snoop_kill_R9: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && (snp_cmd == 2'd2 || snp_cmd == 2'd3)) |=> line_state == 2'd0);

  assert_snoop_first_R10: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && !bus_req_valid) |=> (!cpu_done && !bus_req_valid));

  assert_upgrade_demote_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_req_cmd == 2'd3 && !bus_resp_valid && snp_valid
     && (snp_cmd == 2'd2 || snp_cmd == 2'd3))
    |=> (bus_req_valid && bus_req_cmd == 2'd2));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.DW(DW)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cpu_req_valid   (cpu_req_valid),
  .cpu_req_write   (cpu_req_write),
  .cpu_done        (cpu_done),
  .cpu_rdata       (cpu_rdata),
  .bus_req_valid   (bus_req_valid),
  .bus_req_cmd     (bus_req_cmd),
  .bus_resp_valid  (bus_resp_valid),
  .bus_resp_shared (bus_resp_shared),
  .bus_resp_data   (bus_resp_data),
  .snp_valid       (snp_valid),
  .snp_cmd         (snp_cmd),
  .snp_shared      (snp_shared),
  .snp_flush       (snp_flush),
  .snp_dirty       (snp_dirty),
  .line_state      (line_state)
);

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;
  localparam int DW = 32;
  localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;
  localparam logic [1:0] CRD = 2'd1, CRDX = 2'd2, CUPG = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_v [2];
  logic          req_w [2];
  logic [DW-1:0] wd    [2];
  logic          done  [2];
  logic [DW-1:0] rdat  [2];
  logic          breq  [2];
  logic [1:0]    bcmd  [2];
  logic          rv    [2];
  logic          rsh   [2];
  logic [DW-1:0] rdd   [2];
  logic          snpv  [2];
  logic [1:0]    snpc  [2];
  logic          shs   [2];
  logic          fl    [2];
  logic          dt    [2];
  logic [DW-1:0] sdat  [2];
  logic [1:0]    st    [2];

  mesi_line_ctrl #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .cpu_req_valid(req_v[0]), .cpu_req_write(req_w[0]),
    .cpu_wdata(wd[0]), .cpu_done(done[0]), .cpu_rdata(rdat[0]),
    .bus_req_valid(breq[0]), .bus_req_cmd(bcmd[0]), .bus_resp_valid(rv[0]),
    .bus_resp_shared(rsh[0]), .bus_resp_data(rdd[0]), .snp_valid(snpv[0]),
    .snp_cmd(snpc[0]), .snp_shared(shs[0]), .snp_flush(fl[0]), .snp_dirty(dt[0]),
    .snp_data(sdat[0]), .line_state(st[0]));

  mesi_line_ctrl #(.DW(DW)) uut_peer (
    .clk(clk), .rst(rst), .cpu_req_valid(req_v[1]), .cpu_req_write(req_w[1]),
    .cpu_wdata(wd[1]), .cpu_done(done[1]), .cpu_rdata(rdat[1]),
    .bus_req_valid(breq[1]), .bus_req_cmd(bcmd[1]), .bus_resp_valid(rv[1]),
    .bus_resp_shared(rsh[1]), .bus_resp_data(rdd[1]), .snp_valid(snpv[1]),
    .snp_cmd(snpc[1]), .snp_shared(shs[1]), .snp_flush(fl[1]), .snp_dirty(dt[1]),
    .snp_data(sdat[1]), .line_state(st[1]));

  int vectors = 0;
  int fails   = 0;

  // bus model state
  logic [DW-1:0] mem;
  int            txn;
  logic [1:0]    last_cmd;
  logic [1:0]    cmd_of [2];
  logic          last_sh, last_fl, last_dt;

  // reference model of both caches and memory
  logic [1:0]    mst  [2];
  logic [DW-1:0] mval [2];
  logic [DW-1:0] mmem;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic inv_check();
    logic bad;
    bad = ((st[0] >= SE) && (st[1] != SI)) || ((st[1] >= SE) && (st[0] != SI));
    chk("R12 single owner", {31'd0, bad}, 32'd0);
  endtask

  // bus arbiter and memory: one transaction at a time, cache 0 first
  initial begin
    int m, o;
    m = 0; o = 1;
    for (int i = 0; i < 2; i++) begin
      rv[i] = 0; rsh[i] = 0; rdd[i] = '0; snpv[i] = 0; snpc[i] = 2'd0; cmd_of[i] = 2'd0;
    end
    txn = 0; last_cmd = 0; last_sh = 0; last_fl = 0; last_dt = 0; mem = '0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) rv[i] = 0;
      if (!rst && (breq[0] || breq[1])) begin
        m = breq[0] ? 0 : 1;
        o = 1 - m;
        snpv[o] = 1'b1;
        snpc[o] = bcmd[m];
        last_cmd = bcmd[m];
        cmd_of[m] = bcmd[m];
        @(negedge clk);
        snpv[o] = 1'b0;
        snpc[o] = 2'd0;
        last_sh = shs[o];
        last_fl = fl[o];
        last_dt = dt[o];
        rsh[m] = shs[o];
        rdd[m] = fl[o] ? sdat[o] : mem;
        if (fl[o] && dt[o]) mem = sdat[o];
        rv[m] = 1'b1;
        txn++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic do_op(input int x, input bit wr, input logic [DW-1:0] w, input int dly,
                       output logic [DW-1:0] rd, output int lat);
    repeat (dly) @(negedge clk);
    @(negedge clk);
    req_v[x] = 1'b1; req_w[x] = wr; wd[x] = w; lat = 0;
    do begin
      @(negedge clk);
      lat++;
      inv_check();
    end while (!done[x] && lat < 40);
    if (!done[x]) chk("R12 completion timeout", 32'd0, 32'd1);
    rd = rdat[x];
    req_v[x] = 1'b0;
  endtask

  task automatic do_reset(input logic [DW-1:0] seed);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    mem = seed;
    rst = 1'b0;
    for (int i = 0; i < 2; i++) begin
      mst[i] = SI; mval[i] = '0;
      chk("R1 reset state", {30'd0, st[i]}, 32'd0);
      chk("R1 reset req/done", {30'd0, breq[i], done[i]}, 32'd0);
      chk("R1 reset snoop outs", {29'd0, shs[i], fl[i], dt[i]}, 32'd0);
    end
    mmem = seed;
  endtask

  // reference step, computed from the requirements
  task automatic ref_op(input int x, input bit wr, input logic [DW-1:0] w,
                        output bit bus, output logic [1:0] ecmd, output logic [DW-1:0] erd,
                        output logic esh, output logic efl, output logic edt, output string tag);
    int o;
    o = 1 - x;
    bus = 0; ecmd = 0; erd = '0; esh = 0; efl = 0; edt = 0;
    if (!wr) begin
      if (mst[x] != SI) begin
        tag = "R2 read hit"; erd = mval[x];
      end else begin
        tag = "R3 read miss"; bus = 1; ecmd = CRD; esh = (mst[o] != SI);
        case (mst[o])
          SM: begin efl = 1; edt = 1; mmem = mval[o]; erd = mval[o]; mst[o] = SS; end
          SE: begin efl = 1; erd = mval[o]; mst[o] = SS; end
          default: erd = mmem;
        endcase
        mst[x] = esh ? SS : SE;
        mval[x] = erd;
      end
    end else begin
      case (mst[x])
        SM, SE: begin tag = "R4 write hit"; end
        SS: begin
          tag = "R5 write upgrade"; bus = 1; ecmd = CUPG; esh = (mst[o] != SI);
          mst[o] = SI;
        end
        default: begin
          tag = "R6 write miss"; bus = 1; ecmd = CRDX; esh = (mst[o] != SI);
          if (mst[o] == SM) begin efl = 1; edt = 1; mmem = mval[o]; end
          mst[o] = SI;
        end
      endcase
      mst[x] = SM;
      mval[x] = w;
    end
  endtask

  task automatic step(input int x, input bit wr, input logic [DW-1:0] w);
    bit bus; logic [1:0] ecmd; logic [DW-1:0] erd, rd; logic esh, efl, edt;
    string tag; int lat, t0;
    ref_op(x, wr, w, bus, ecmd, erd, esh, efl, edt, tag);
    t0 = txn;
    do_op(x, wr, w, 0, rd, lat);
    chk({tag, " state self"}, {30'd0, st[x]}, {30'd0, mst[x]});
    chk({tag, " state other"}, {30'd0, st[1-x]}, {30'd0, mst[1-x]});
    chk({tag, " bus used"}, txn - t0, bus ? 1 : 0);
    if (!wr) chk({tag, " data"}, rd, erd);
    if (!bus) chk({tag, " one-cycle"}, lat, 1);
    else begin
      chk({tag, " command"}, {30'd0, last_cmd}, {30'd0, ecmd});
      chk("R7 shared reply", {31'd0, last_sh}, {31'd0, esh});
      chk("R8/R9 supply", {30'd0, last_fl, last_dt}, {30'd0, efl, edt});
    end
  endtask

  initial begin
    logic [DW-1:0] rd0, rd1;
    int l0, l1;
    for (int i = 0; i < 2; i++) begin req_v[i] = 0; req_w[i] = 0; wd[i] = '0; end

    // near-exhaustive sweep: every sequence of three operations from reset
    for (int s = 0; s < 64; s++) begin
      do_reset(32'h5000 + s);
      for (int k = 0; k < 3; k++) begin
        int op;
        op = (s >> (2 * k)) & 3;
        step(op >> 1, op[0], 32'hA000 + s * 16 + k);
      end
      // final read from both sides checks data agreement (R12)
      step(0, 1'b0, '0);
      step(1, 1'b0, '0);
    end

    // R10: write to Exclusive line lands in the cycle a peer read is snooped
    do_reset(32'h7777);
    step(0, 1'b0, '0);
    fork
      do_op(1, 1'b0, '0, 0, rd1, l1);
      do_op(0, 1'b1, 32'hBEEF, 1, rd0, l0);
    join
    chk("R10 peer read data", rd1, 32'h7777);
    chk("R10 writer state", {30'd0, st[0]}, {30'd0, SM});
    chk("R10 peer state", {30'd0, st[1]}, {30'd0, SI});
    chk("R10 writer used upgrade", {30'd0, cmd_of[0]}, {30'd0, CUPG});
    chk("R10 peer used read", {30'd0, cmd_of[1]}, {30'd0, CRD});
    do_op(1, 1'b0, '0, 0, rd1, l1);
    chk("R10 later read", rd1, 32'hBEEF);

    // R11: both Shared holders write together
    do_reset(32'h1234);
    step(0, 1'b0, '0);
    step(1, 1'b0, '0);
    fork
      do_op(0, 1'b1, 32'hAAAA, 0, rd0, l0);
      do_op(1, 1'b1, 32'hBBBB, 0, rd1, l1);
    join
    chk("R11 winner upgrade", {30'd0, cmd_of[0]}, {30'd0, CUPG});
    chk("R11 loser demoted", {30'd0, cmd_of[1]}, {30'd0, CRDX});
    chk("R11 winner state", {30'd0, st[0]}, {30'd0, SI});
    chk("R11 loser state", {30'd0, st[1]}, {30'd0, SM});
    chk("R11 memory written back", mem, 32'hAAAA);
    do_op(0, 1'b0, '0, 0, rd0, l0);
    chk("R11 later read", rd0, 32'hBBBB);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule